// File: doc/BRIEF.md
# Exclusive-Access Reservation Tracker

This block holds the one reservation that a 32-bit core uses to pair an exclusive load with a later conditional store. An exclusive-load pulse opens a reservation and records the word address. A conditional-store pulse is resolved in the same cycle. If a reservation is open, the store is performed and the carry flag is cleared. If none is open, the store is suppressed and carry is set. The conditional store then closes the reservation whatever its outcome.

The reserved address is kept at word granularity and is shown only for debug. It never decides whether a store succeeds: any open reservation lets any conditional store through. Soft reset, interrupt entry, exception entry and break entry (hardware or software) each close the reservation. All inputs are one-cycle control pulses from the core's pipeline. There is no data stream, so there is no valid/ready handshake and the block applies no back-pressure. The load/store path must sample `store_go_o` and `carry_o` in the same cycle it raises `sc_issue_i`.

Top module: `excl_resv_tracker`

## Requirements
- R1: After hardware reset (`rst_n` low) the reservation is closed: `resv_open_o` = 0 and `resv_word_o` = 0.
- R2: An `excl_ld_i` pulse with no clear event and no `sc_issue_i` in the same cycle opens the reservation from the next cycle (`resv_open_o` = 1).
- R3: A later exclusive load while a reservation is open replaces the recorded word address. Only one reservation exists.
- R4: In a cycle with `sc_issue_i` = 1 and an open reservation, `store_go_o` = 1 and `carry_o` = 0 in that same cycle.
- R5: In a cycle with `sc_issue_i` = 1 and no open reservation, `store_go_o` = 0 and `carry_o` = 1 in that same cycle.
- R6: Store success does not depend on the address: a conditional store to a word other than the reserved one still succeeds while a reservation is open.
- R7: Every conditional store closes the reservation from the next cycle, whether it succeeded or failed. This also holds when an exclusive load arrives in the same cycle.
- R8: Each of `soft_rst_i`, `irq_take_i`, `exc_take_i` and `brk_take_i`, alone or combined, closes the reservation from the next cycle.
- R9: A clear event in the same cycle as `excl_ld_i` wins: the reservation is closed afterwards.
- R10: The recorded address is `addr_i[31:2]`, a 30-bit word index. Byte-offset bits 1:0 are ignored, and unaligned addresses are accepted without any fault.
- R11: In a cycle without `sc_issue_i`, both `store_go_o` and `carry_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, synchronous |
| excl_ld_i | input | 1 | Exclusive load issued this cycle |
| sc_issue_i | input | 1 | Conditional store issued this cycle |
| soft_rst_i | input | 1 | Core reset event pulse |
| irq_take_i | input | 1 | Interrupt taken pulse |
| exc_take_i | input | 1 | Exception taken pulse |
| brk_take_i | input | 1 | Break taken pulse (hardware or software) |
| addr_i | input | 32 | Byte address of the exclusive access |
| store_go_o | output | 1 | Perform the conditional store (combinational) |
| carry_o | output | 1 | Carry result: 1 = store failed (combinational) |
| resv_open_o | output | 1 | Reservation currently open (debug) |
| resv_word_o | output | 30 | Recorded word address (debug) |

## Verification
The bench sweeps all 64 combinations of the six event pulses, starting once from an open reservation and once from a closed one.

- A design that compared addresses would fail a store whose word differs from the reserved one.
- A design that let the load win over a clear would leave a stale reservation after an interrupt, exception or break.
- A design that cleared only on a successful store would let a second store succeed after a failed one.
- Low address bits are varied on every load, so a design that stored byte offsets would show a wrong word index.

// File: rtl/excl_resv_pkg.sv
package excl_resv_pkg;

  // Sources that discard an outstanding reservation.
  typedef struct packed {
    logic soft_rst;
    logic irq;
    logic exc;
    logic brk;
  } kill_src_t;

  localparam int unsigned KILL_SRC_N = $bits(kill_src_t);

endpackage

// File: rtl/resv_kill_merge.sv
module resv_kill_merge
  import excl_resv_pkg::*;
(
  input  kill_src_t src_i,
  input  logic      sc_issue_i,
  output logic      evt_kill_o,
  output logic      any_kill_o
);

  logic [KILL_SRC_N-1:0] flat;
  assign flat = src_i;

  always_comb begin
    evt_kill_o = 1'b0;
    for (int k = 0; k < KILL_SRC_N; k++) begin
      evt_kill_o = evt_kill_o | flat[k];
    end
    any_kill_o = evt_kill_o | sc_issue_i;
  end

endmodule

// File: rtl/resv_hold.sv
module resv_hold #(
  parameter int unsigned TAG_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill_i,
  input  logic             set_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             open_o,
  output logic [TAG_W-1:0] tag_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      tag_o  <= '0;
    end else if (kill_i) begin
      open_o <= 1'b0;
    end else if (set_i) begin
      open_o <= 1'b1;
      tag_o  <= tag_i;
    end
  end

  assert_kill_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> !open_o);

  assert_set_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !kill_i) |=> (open_o && tag_o == $past(tag_i)));

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !kill_i) |=> ($stable(open_o) && $stable(tag_o)));

endmodule

// File: rtl/sc_outcome.sv
module sc_outcome (
  input  logic clk,
  input  logic rst_n,
  input  logic sc_issue_i,
  input  logic open_i,
  output logic go_o,
  output logic carry_o
);

  always_comb begin
    go_o    = 1'b0;
    carry_o = 1'b0;
    if (sc_issue_i) begin
      if (open_i) go_o    = 1'b1;
      else        carry_o = 1'b1;
    end
  end

  assert_one_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_o, carry_o}));

  assert_sc_reports_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sc_issue_i |-> ($countones({go_o, carry_o}) == 1));

endmodule

// File: rtl/excl_resv_tracker.sv
module excl_resv_tracker
  import excl_resv_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           excl_ld_i,
  input  logic                           sc_issue_i,
  input  logic                           soft_rst_i,
  input  logic                           irq_take_i,
  input  logic                           exc_take_i,
  input  logic                           brk_take_i,
  input  logic [31:0]                    addr_i,
  output logic                           store_go_o,
  output logic                           carry_o,
  output logic                           resv_open_o,
  output logic [29:0]                    resv_word_o
);

  localparam int unsigned OFF_W = $clog2(WORD_BYTES);
  localparam int unsigned TAG_W = ADDR_W - OFF_W;

  kill_src_t        srcs;
  logic             evt_kill;
  logic             any_kill;
  logic [TAG_W-1:0] held_tag;
  logic             unused_offset_bits;

  assign srcs = '{soft_rst: soft_rst_i, irq: irq_take_i,
                  exc: exc_take_i, brk: brk_take_i};
  assign unused_offset_bits = ^addr_i[OFF_W-1:0];

  resv_kill_merge u_kill (
    .src_i      (srcs),
    .sc_issue_i (sc_issue_i),
    .evt_kill_o (evt_kill),
    .any_kill_o (any_kill)
  );

  resv_hold #(.TAG_W(TAG_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .kill_i (any_kill),
    .set_i  (excl_ld_i),
    .tag_i  (addr_i[ADDR_W-1:OFF_W]),
    .open_o (resv_open_o),
    .tag_o  (held_tag)
  );

  sc_outcome u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .sc_issue_i (sc_issue_i),
    .open_i     (resv_open_o),
    .go_o       (store_go_o),
    .carry_o    (carry_o)
  );

  assign resv_word_o = held_tag;

  assert_sc_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sc_issue_i |=> !resv_open_o);

  assert_event_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_i || irq_take_i || exc_take_i || brk_take_i) |=> !resv_open_o);

  assert_sc_after_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(excl_ld_i) && !$past(evt_kill) && !$past(sc_issue_i) && sc_issue_i)
      |-> (store_go_o && !carry_o));

  assert_sc_after_kill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(any_kill) && sc_issue_i) |-> (!store_go_o && carry_o));

endmodule

// File: tb/tb_excl_resv_tracker.sv
module tb_excl_resv_tracker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        excl_ld_i, sc_issue_i, soft_rst_i, irq_take_i, exc_take_i, brk_take_i;
  logic [31:0] addr_i;
  logic        store_go_o, carry_o, resv_open_o;
  logic [29:0] resv_word_o;

  int n_chk = 0;
  int n_bad = 0;

  bit          m_open;
  logic [29:0] m_word;

  always #2 clk = ~clk;

  excl_resv_tracker dut (
    .clk(clk), .rst_n(rst_n), .excl_ld_i(excl_ld_i), .sc_issue_i(sc_issue_i),
    .soft_rst_i(soft_rst_i), .irq_take_i(irq_take_i), .exc_take_i(exc_take_i),
    .brk_take_i(brk_take_i), .addr_i(addr_i), .store_go_o(store_go_o),
    .carry_o(carry_o), .resv_open_o(resv_open_o), .resv_word_o(resv_word_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    excl_ld_i = 0; sc_issue_i = 0; soft_rst_i = 0;
    irq_take_i = 0; exc_take_i = 0; brk_take_i = 0;
  endtask

  // Called at a negedge: drive one cycle of pulses, check in-cycle outputs,
  // then check registered state at the following negedge.
  task automatic step(input bit ld, input bit st, input bit sr, input bit iq,
                      input bit ex, input bit bk, input logic [31:0] a);
    bit          clr;
    bit          exp_go, exp_cy;
    string       rq;
    clr = sr | iq | ex | bk;
    excl_ld_i = ld; sc_issue_i = st; soft_rst_i = sr;
    irq_take_i = iq; exc_take_i = ex; brk_take_i = bk; addr_i = a;
    #1;
    exp_go = st & m_open;
    exp_cy = st & !m_open;
    if (!st) rq = "R11";
    else if (m_open && (a[31:2] != m_word)) rq = "R6";
    else if (m_open) rq = "R4";
    else rq = "R5";
    check(store_go_o == exp_go, {rq, " store_go"}, 32'(store_go_o), 32'(exp_go));
    check(carry_o == exp_cy, {rq, " carry"}, 32'(carry_o), 32'(exp_cy));
    if (st) begin
      m_open = 0; rq = "R7";
    end else if (clr) begin
      m_open = 0; rq = ld ? "R9" : "R8";
    end else if (ld) begin
      rq = m_open ? "R3" : "R2";
      m_open = 1; m_word = a[31:2];
    end else rq = "R3 hold";
    @(negedge clk);
    idle_inputs();
    check(resv_open_o == m_open, {rq, " open"}, 32'(resv_open_o), 32'(m_open));
    if (m_open)
      check(resv_word_o == m_word, "R10 word", 32'(resv_word_o), 32'(m_word));
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; idle_inputs(); addr_i = 32'h0;
    m_open = 0; m_word = '0;
    repeat (3) @(negedge clk);
    check(resv_open_o == 0, "R1 open", 32'(resv_open_o), 32'h0);
    check(resv_word_o == 0, "R1 word", 32'(resv_word_o), 32'h0);
    rst_n = 1;
    @(negedge clk);

    // Replacement: two loads, then success on a foreign address.
    step(1, 0, 0, 0, 0, 0, 32'h0000_1003);
    step(1, 0, 0, 0, 0, 0, 32'h0000_2001);
    step(0, 1, 0, 0, 0, 0, 32'h0000_9000);
    // Second store after a store must fail.
    step(0, 1, 0, 0, 0, 0, 32'h0000_2000);

    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 64; c++) begin
        logic [31:0] a;
        a = 32'h4000_0000 + 32'(c * 4) + 32'(c % 4);
        if (s == 1) step(1, 0, 0, 0, 0, 0, 32'h8000_0000 + 32'(c * 8) + 32'(3 - c % 4));
        else        step(0, 0, 1, 0, 0, 0, 32'h0);
        step(c[0], c[1], c[2], c[3], c[4], c[5], a);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule